// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Configuration

This block is a parameterized port of general-purpose pins (32 by default) sitting behind a simple word-addressed register bus. Software can write the output level register as a whole word. It can also set or clear individual bits through two strobe registers. The direction of every pin can be changed the same way. Each pin also owns a small configuration word. That word carries the pin's direction bit, a bit that disconnects the input buffer, and a two-bit pull selector.

On every clock the block works out a level for each pin and stores it in the sampled-input register. Three things feed that level: the pin's own output driver, the external source, and the pull setting. The external source can drive high, drive low, or float. When the external source floats and nothing else decides the level, the stored value is kept. The block also presents its output levels and output enables to the pad ring. If a pin driven as an output sees the external source drive the opposite level, the block latches a sticky conflict flag.

Word addresses are as follows:

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | Output level | Output levels | Replace all output levels |
| 1 | Output set | Output levels | Set bits where the data has ones |
| 2 | Output clear | Output levels | Clear bits where the data has ones |
| 3 | Sampled input | Sampled input | No effect |
| 4 | Direction | Direction bits | Replace all direction bits |
| 5 | Direction set | Direction bits | Set bits where the data has ones |
| 6 | Direction clear | Direction bits | Clear bits where the data has ones |
| 7 | Status | Bit 0 is the conflict flag | Writing 1 to bit 0 clears the flag |
| NPINS + n | Configuration of pin n | Configuration word | Configuration word |

Top module: `gpio_port`

## Requirements
- R1: After reset these registers all read 0: output level (address 0), output set (1), output clear (2), sampled input (3), direction (4), direction set (5), direction clear (6) and status (7). Every per-pin configuration word reads 0x2. Both pin_out and pin_oe are 0.
- R2: A write to address 5 sets the direction bits where the written word has ones. A write to address 6 clears them where it has ones. A write to address 4 replaces all direction bits. Addresses 4, 5 and 6 all read back the direction bits, and pin_oe equals the direction bits.
- R3: Bit 0 of the configuration word of pin n (address NPINS+n) is the same storage as direction bit n. A change made through either view reads back through the other.
- R4: The configuration word has four fields. Bit 0 is the direction (1 means output). Bit 1 set disconnects the input buffer. Bits 3:2 select the pull: 0 means none, 1 means pull-down, 3 means pull-up, and 2 acts as none. Bits above bit 3 read 0.
- R5: For an input pin (bit 0 = 0) with its buffer connected and no pull, the sampled input bit takes the external level one clock after that level is presented. While the external source floats, the bit keeps its last value.
- R6: When the input buffer is disconnected, the pull alone decides the sampled bit. Pull-up gives 1 and pull-down gives 0, whatever the external source drives. With no pull, the bit keeps its last value.
- R7: Writes to address 1 set, and writes to address 2 clear, the output bits where the data has ones. Zero bits leave those output bits unchanged. Both addresses read back the output levels, and pin_out equals the output levels.
- R8: For an output pin with its buffer connected (configuration 0b01), the sampled input bit follows the pin's own output level, with a delay of one clock.
- R9: For a connected input pin whose external source floats, pull-up gives a sampled 1 and pull-down gives a sampled 0. A driven external level takes priority over the pull.
- R10: A pin with its direction set to output, whose external source drives the opposite level, sets err_flag (status bit 0) on the next clock. A matching external level does not set it.
- R11: err_flag stays set until software writes 1 to status bit 0. If a conflict is present in the same cycle as that clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW = log2(2*NPINS) | Word address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational from bus_addr |
| ext_lvl | input | NPINS | Level that the external source drives |
| ext_drv | input | NPINS | 1 where the external source is driving, 0 where it floats |
| pin_out | output | NPINS | Output level of each pin |
| pin_oe | output | NPINS | Output enable (direction) of each pin |
| err_flag | output | 1 | Sticky drive-conflict flag |

## Verification
Two actions can fall in the same cycle: a drive conflict that sets the status flag, and a software write that clears it. The bench provokes this by holding a pin as a high output while the external source pulls it low, then issuing the clear write. It reads status in the half cycle right after that write, so a clear that wins over the set would show as 0 before the conflict could set the flag again. Once the external drive is released, a second clear must leave the flag at 0.

// File: rtl/gpio_pkg.sv
// Shared constants and types for the GPIO port.
// Assumes the per-pin configuration words sit in the upper half of the
// word address space, so the address MSB selects them.
package gpio_pkg;

    // Word addresses of the port-wide registers
    localparam int ADR_OUT    = 0;
    localparam int ADR_OUTSET = 1;
    localparam int ADR_OUTCLR = 2;
    localparam int ADR_IN     = 3;
    localparam int ADR_DIR    = 4;
    localparam int ADR_DIRSET = 5;
    localparam int ADR_DIRCLR = 6;
    localparam int ADR_STAT   = 7;

    // Pull selector codes
    localparam logic [1:0] PULL_NONE = 2'b00;
    localparam logic [1:0] PULL_DOWN = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b11;

    // Configuration word of one pin, bit 0 at the right
    typedef struct packed {
        logic [1:0] pull;
        logic       disc;
        logic       dir;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{pull: PULL_NONE, disc: 1'b1, dir: 1'b0};

endpackage

// File: rtl/gpio_bus_decode.sv
// Turns one bus write into per-register write strobes.
// Assumes NPINS is a power of two: the address MSB selects the
// configuration words and the low bits give the pin index.
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int AW   = $clog2(2 * NPINS)
) (
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    output logic             wr_out,
    output logic             wr_outset,
    output logic             wr_outclr,
    output logic             wr_dir,
    output logic             wr_dirset,
    output logic             wr_dirclr,
    output logic             wr_stat,
    output logic [NPINS-1:0] wr_cfg
);

    logic low_wr;

    // A write to the lower half reaches a port-wide register
    assign low_wr    = bus_wr && !bus_addr[AW-1];
    assign wr_out    = low_wr && (bus_addr == AW'(ADR_OUT));
    assign wr_outset = low_wr && (bus_addr == AW'(ADR_OUTSET));
    assign wr_outclr = low_wr && (bus_addr == AW'(ADR_OUTCLR));
    assign wr_dir    = low_wr && (bus_addr == AW'(ADR_DIR));
    assign wr_dirset = low_wr && (bus_addr == AW'(ADR_DIRSET));
    assign wr_dirclr = low_wr && (bus_addr == AW'(ADR_DIRCLR));
    assign wr_stat   = low_wr && (bus_addr == AW'(ADR_STAT));

    // One strobe per configuration word in the upper half
    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        assign wr_cfg[i] = bus_wr && bus_addr[AW-1] && (bus_addr[AW-2:0] == (AW-1)'(i));
    end

endmodule

// File: rtl/gpio_pin_cell.sv
// State and level resolution for one pin: output bit, configuration
// (its bit 0 is the direction bit), and the registered sampled input.
// Assumes at most one write strobe is active per cycle.
module gpio_pin_cell
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_out,
    input  logic     wr_outset,
    input  logic     wr_outclr,
    input  logic     wr_dir,
    input  logic     wr_dirset,
    input  logic     wr_dirclr,
    input  logic     wr_cfg,
    input  logic     wbit,
    input  pin_cfg_t cfg_wdata,
    input  logic     ext_lvl,
    input  logic     ext_drv,
    output logic     out_q,
    output pin_cfg_t cfg_q,
    output logic     in_q,
    output logic     conflict
);

    logic lvl_nxt;

    // Output level register: full write, set-by-one, clear-by-one
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_q <= 1'b0;
        else if (wr_out)             out_q <= wbit;
        else if (wr_outset && wbit)  out_q <= 1'b1;
        else if (wr_outclr && wbit)  out_q <= 1'b0;
    end

    // Direction bit, reachable from the direction registers and the config word
    always_ff @(posedge clk) begin
        if (!rst_n)                  cfg_q.dir <= CFG_RESET.dir;
        else if (wr_cfg)             cfg_q.dir <= cfg_wdata.dir;
        else if (wr_dir)             cfg_q.dir <= wbit;
        else if (wr_dirset && wbit)  cfg_q.dir <= 1'b1;
        else if (wr_dirclr && wbit)  cfg_q.dir <= 1'b0;
    end

    // Input-disconnect and pull fields, written only through the config word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.disc <= CFG_RESET.disc;
            cfg_q.pull <= CFG_RESET.pull;
        end else if (wr_cfg) begin
            cfg_q.disc <= cfg_wdata.disc;
            cfg_q.pull <= cfg_wdata.pull;
        end
    end

    // Resolve the level: disconnect→pull, own driver, external, pull, else hold
    always_comb begin
        lvl_nxt = in_q;
        if (cfg_q.disc) begin
            if (cfg_q.pull == PULL_UP)        lvl_nxt = 1'b1;
            else if (cfg_q.pull == PULL_DOWN) lvl_nxt = 1'b0;
        end else if (cfg_q.dir) begin
            lvl_nxt = out_q;
        end else if (ext_drv) begin
            lvl_nxt = ext_lvl;
        end else if (cfg_q.pull == PULL_UP) begin
            lvl_nxt = 1'b1;
        end else if (cfg_q.pull == PULL_DOWN) begin
            lvl_nxt = 1'b0;
        end
    end

    // Sampled input register
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= 1'b0;
        else        in_q <= lvl_nxt;
    end

    // Own driver fights an opposite external drive
    assign conflict = cfg_q.dir && ext_drv && (ext_lvl != out_q);

endmodule

// File: rtl/gpio_port.sv
// GPIO port top: bus decode, one pin cell per pin, read mux and the
// sticky conflict flag. Assumes NPINS is a power of two and >= 8.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int AW   = $clog2(2 * NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] ext_lvl,
    input  logic [NPINS-1:0] ext_drv,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             err_flag
);

    logic             wr_out, wr_outset, wr_outclr;
    logic             wr_dir, wr_dirset, wr_dirclr, wr_stat;
    logic [NPINS-1:0] wr_cfg;
    logic [NPINS-1:0] out_vec, dir_vec, in_vec, conf_vec;
    pin_cfg_t         cfg_arr [NPINS];
    pin_cfg_t         cfg_wdata;
    pin_cfg_t         cfg_rd;

    assign cfg_wdata = pin_cfg_t'(bus_wdata[3:0]);

    gpio_bus_decode #(.NPINS(NPINS)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_out    (wr_out),
        .wr_outset (wr_outset),
        .wr_outclr (wr_outclr),
        .wr_dir    (wr_dir),
        .wr_dirset (wr_dirset),
        .wr_dirclr (wr_dirclr),
        .wr_stat   (wr_stat),
        .wr_cfg    (wr_cfg)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_out    (wr_out),
            .wr_outset (wr_outset),
            .wr_outclr (wr_outclr),
            .wr_dir    (wr_dir),
            .wr_dirset (wr_dirset),
            .wr_dirclr (wr_dirclr),
            .wr_cfg    (wr_cfg[i]),
            .wbit      (bus_wdata[i]),
            .cfg_wdata (cfg_wdata),
            .ext_lvl   (ext_lvl[i]),
            .ext_drv   (ext_drv[i]),
            .out_q     (out_vec[i]),
            .cfg_q     (cfg_arr[i]),
            .in_q      (in_vec[i]),
            .conflict  (conf_vec[i])
        );
        assign dir_vec[i] = cfg_arr[i].dir;
    end

    // Sticky conflict flag; a new conflict wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)                      err_flag <= 1'b0;
        else if (|conf_vec)              err_flag <= 1'b1;
        else if (wr_stat && bus_wdata[0]) err_flag <= 1'b0;
    end

    assign cfg_rd = cfg_arr[bus_addr[AW-2:0]];

    // Read mux for all registers
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[AW-1]) begin
            bus_rdata = {{(NPINS-4){1'b0}}, cfg_rd};
        end else begin
            case (bus_addr)
                AW'(ADR_OUT), AW'(ADR_OUTSET), AW'(ADR_OUTCLR): bus_rdata = out_vec;
                AW'(ADR_IN):                                    bus_rdata = in_vec;
                AW'(ADR_DIR), AW'(ADR_DIRSET), AW'(ADR_DIRCLR): bus_rdata = dir_vec;
                AW'(ADR_STAT):                                  bus_rdata = {{(NPINS-1){1'b0}}, err_flag};
                default:                                        bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_vec;
    assign pin_oe  = dir_vec;

endmodule

// File: rtl/gpio_port_chk.sv
// Port-level properties of the GPIO port, bound to every instance.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int AW   = $clog2(2 * NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] ext_lvl,
    input logic [NPINS-1:0] ext_drv,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             err_flag
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !err_flag));

    // R7
    outset_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_OUTSET)) |=> pin_out == $past(pin_out | bus_wdata));

    // R7
    outclr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_OUTCLR)) |=> pin_out == $past(pin_out & ~bus_wdata));

    // R2
    dirset_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_DIRSET)) |=> pin_oe == $past(pin_oe | bus_wdata));

    // R2
    dirclr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_DIRCLR)) |=> pin_oe == $past(pin_oe & ~bus_wdata));

    // R10
    conflict_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ext_drv & (pin_out ^ ext_lvl)) != '0) |=> err_flag);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(bus_wr && bus_addr == AW'(ADR_STAT) && bus_wdata[0])) |=> err_flag);

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_STAT) && bus_wdata[0]
         && ((pin_oe & ext_drv & (pin_out ^ ext_lvl)) == '0)) |=> !err_flag);

endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ext_lvl   (ext_lvl),
    .ext_drv   (ext_drv),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .err_flag  (err_flag)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
// Directed bench for gpio_port: one task per scenario.
module sim_gpio_port;

    localparam int NPINS = 32;
    localparam int AW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [NPINS-1:0] bus_wdata = '0;
    logic [NPINS-1:0] bus_rdata;
    logic [NPINS-1:0] ext_lvl = '0;
    logic [NPINS-1:0] ext_drv = '0;
    logic [NPINS-1:0] pin_out;
    logic [NPINS-1:0] pin_oe;
    logic             err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_port #(.NPINS(NPINS)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_lvl   (ext_lvl),
        .ext_drv   (ext_drv),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .err_flag  (err_flag)
    );

    always #2 clk = ~clk;

    // Compare and count
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One-cycle bus write; returns at the falling edge after the write edge
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational read without waiting for a clock
    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #0.5;
        d = bus_rdata;
    endtask

    task automatic expect_rd(input string req, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // Let the sampled input register take one more edge
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) expect_rd("R1 reg", a, 32'h0);
        expect_rd("R1 cfg0", 32, 32'h2);
        expect_rd("R1 cfg31", 63, 32'h2);
        check("R1 pins", {pin_out | pin_oe}, 32'h0);
    endtask

    task automatic t_dir();
        wr(5, 32'h8000_0001);
        expect_rd("R2 dirset", 4, 32'h8000_0001);
        check("R2 oe", pin_oe, 32'h8000_0001);
        expect_rd("R3 cfg0 dir", 32, 32'h3);
        expect_rd("R3 cfg31 dir", 63, 32'h3);
        wr(6, 32'h8000_0001);
        expect_rd("R2 dirclr", 6, 32'h0);
        expect_rd("R3 cfg31 after clr", 63, 32'h2);
        wr(4, 32'h8000_0001);
        expect_rd("R2 dir write", 5, 32'h8000_0001);
        wr(37, 32'hFFFF_FFF1);
        expect_rd("R3 cfg5 to dir", 4, 32'h8000_0021);
        expect_rd("R4 cfg5 upper bits", 37, 32'h1);
        wr(4, 32'h0);
        expect_rd("R3 dir to cfg5", 37, 32'h0);
    endtask

    task automatic t_input();
        wr(32, 32'h0);
        ext_drv[0] = 1'b1; ext_lvl[0] = 1'b0;
        settle(); settle();
        expect_rd("R5 ext low", 3, 32'h0);
        @(negedge clk); ext_lvl[0] = 1'b1;
        settle();
        expect_rd("R5 ext high", 3, 32'h1);
        @(negedge clk); ext_drv[0] = 1'b0; ext_lvl[0] = 1'b0;
        settle(); settle();
        expect_rd("R5 float holds", 3, 32'h1);
        wr(32, 32'h4);
        settle();
        expect_rd("R9 float pulldown", 3, 32'h0);
        wr(32, 32'hC);
        settle();
        expect_rd("R9 float pullup", 3, 32'h1);
        @(negedge clk); ext_drv[0] = 1'b1; ext_lvl[0] = 1'b0;
        settle();
        expect_rd("R9 drive beats pull", 3, 32'h0);
    endtask

    task automatic t_pull();
        ext_drv[0] = 1'b1; ext_lvl[0] = 1'b0;
        wr(32, 32'h0);
        settle();
        expect_rd("R6 base low", 3, 32'h0);
        wr(32, 32'hE);
        settle();
        expect_rd("R6 disc pullup", 3, 32'h1);
        wr(32, 32'h2);
        @(negedge clk); ext_lvl[0] = 1'b1;
        settle(); settle();
        expect_rd("R6 disc nopull holds", 3, 32'h1);
        wr(32, 32'h6);
        settle();
        expect_rd("R6 disc pulldown", 3, 32'h0);
        wr(32, 32'h2);
        @(negedge clk); ext_drv[0] = 1'b0; ext_lvl[0] = 1'b0;
    endtask

    task automatic t_out();
        wr(32, 32'h3);
        wr(1, 32'h1);
        check("R7 outset line", pin_out, 32'h1);
        expect_rd("R7 outset reads out", 1, 32'h1);
        wr(1, 32'h0);
        expect_rd("R7 outset zero", 0, 32'h1);
        wr(2, 32'h0);
        expect_rd("R7 outclr zero", 2, 32'h1);
        wr(2, 32'h1);
        check("R7 outclr line", pin_out, 32'h0);
        wr(0, 32'hA5);
        check("R7 whole write", pin_out, 32'hA5);
        wr(0, 32'h0);
    endtask

    task automatic t_loop();
        wr(32, 32'h1);
        wr(1, 32'h1);
        settle();
        expect_rd("R8 loop high", 3, 32'h1);
        wr(2, 32'h1);
        settle();
        expect_rd("R8 loop low", 3, 32'h0);
    endtask

    task automatic t_short();
        wr(1, 32'h1);
        @(negedge clk); ext_drv[0] = 1'b1; ext_lvl[0] = 1'b1;
        settle();
        expect_rd("R10 same level no error", 7, 32'h0);
        @(negedge clk); ext_lvl[0] = 1'b0;
        settle();
        check("R10 conflict flag", {31'h0, err_flag}, 32'h1);
        wr(7, 32'h1);
        expect_rd("R11 set wins over clear", 7, 32'h1);
        @(negedge clk); ext_drv[0] = 1'b0;
        settle();
        expect_rd("R11 sticky", 7, 32'h1);
        wr(7, 32'h0);
        expect_rd("R11 zero write keeps", 7, 32'h1);
        wr(7, 32'h1);
        expect_rd("R11 cleared", 7, 32'h0);
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_input();
        t_pull();
        t_out();
        t_loop();
        t_short();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule